// File: doc/BRIEF.md
# Linked-Descriptor Frame Fetcher

This block feeds a display pipeline from memory by walking a chain of descriptors. Each descriptor is a four-word record holding the address of the following descriptor, a source address, an identifier word that is read and discarded, and a command word. The command word gives a length in 32-bit words and a flag that sends the data either to an internal pixel FIFO or to a palette RAM write port. After one transfer ends, the block follows the next pointer and starts the following one. A descriptor that points to itself repeats one frame buffer for as long as the block runs. Two descriptors that point to each other alternate a palette reload with a frame pass.

Software places the chain in memory, writes the address of its first descriptor to `start_addr` and raises `enable`. The walk begins on the next `frame_start` pulse from the timing generator. Memory is read through a request/response port, one burst outstanding at a time. The display side pulls pixel words with `pix_rd`. If the FIFO is empty when a word is pulled, the last word is shown again and a sticky flag is set.

Top module: `frame_dma_fetch`

## Requirements
- R1: After reset, no memory request is raised, `pix_data` is 0, `underrun` is 0 and `pal_we` is 0.
- R2: Once `enable` is high, nothing is fetched until a `frame_start` pulse. The first request then reads 4 words at `start_addr`, and the descriptor words arrive in the order next pointer, source address, identifier (ignored), command.
- R3: Bits 23:0 of the command word give the transfer length in 32-bit words, and bit 28 set marks a palette transfer. A length of 0 moves straight on to the descriptor named by the next pointer.
- R4: Transfer data is read in bursts of min(16, words left). The first burst starts at the source address and each following burst starts 64 bytes further on.
- R5: A pixel burst is requested only while the 32-word FIFO has at least 16 free entries. With no words pulled, at most 32 pixel words are ever requested. Palette bursts are not held back by the FIFO.
- R6: Pixel words come out of `pix_data` in memory order, one cycle after the `pix_rd` cycle that pulls them. When a transfer ends, the next pointer is followed, so a descriptor that points to itself repeats its buffer.
- R7: Palette transfer words never enter the FIFO. Each word becomes two 16-bit writes, low half first, to palette addresses that start at 0 for every palette transfer and rise by one per write.
- R8: In a chain where a palette descriptor and a frame descriptor point at each other, the palette is rewritten before every frame pass, and only frame words reach `pix_data`.
- R9: A memory request that is not accepted stays raised with the same address and length.
- R10: A `pix_rd` while the FIFO is empty leaves `pix_data` at its last value and sets `underrun`, which stays set until reset.
- R11: A `frame_start` pulse while the chain is running has no effect. Dropping `enable` lets the current transfer finish, and then no further request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the descriptor walk |
| start_addr | input | 32 | Byte address of the first descriptor |
| frame_start | input | 1 | One-cycle pulse from the timing generator |
| mem_req_valid | output | 1 | Read request raised |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the first word to read |
| mem_req_len | output | 5 | Number of words in the request (1 to 16) |
| mem_rsp_valid | input | 1 | Response word present |
| mem_rsp_ready | output | 1 | Block takes the response word |
| mem_rsp_data | input | 32 | Response word, in address order |
| pix_rd | input | 1 | Pull one pixel word |
| pix_data | output | 32 | Last pulled pixel word |
| underrun | output | 1 | Sticky: a pull found the FIFO empty |
| pal_we | output | 1 | Palette entry write strobe |
| pal_addr | output | 8 | Palette entry index |
| pal_wdata | output | 16 | Palette entry value |

## Verification
If the walker captures the wrong descriptor field, or follows the wrong next pointer, the request address shows it on the first request of the following transfer. The pixel stream also goes out of order within one buffer length. A burst counter that is off by one shows up as a burst length other than min(16, left) or as a burst that starts at the wrong address. A room check that is too loose shows up as more than 32 pixel words requested while nothing is pulled. An unpacker fault shows up as a palette write at the wrong index or with the wrong half, at the latest two cycles after the response word arrives. A wrong FIFO count shows up as a spurious or missing `underrun`, or as a repeated or skipped pixel word.

// File: rtl/frame_dma_pkg.sv
package frame_dma_pkg;
  localparam int WORD_W       = 32;
  localparam int DESC_WORDS   = 4;
  localparam int LEN_FIELD_W  = 24;
  localparam int PAL_FLAG_BIT = 28;

  typedef enum logic [2:0] {
    ST_IDLE,  // not running
    ST_ARM,   // waiting for frame start
    ST_DREQ,  // request descriptor
    ST_DRSP,  // collect descriptor words
    ST_XREQ,  // request a data burst
    ST_XRSP   // collect data burst
  } walk_st_t;

  function automatic logic [LEN_FIELD_W-1:0] cmd_words(input logic [WORD_W-1:0] cmd);
    return cmd[LEN_FIELD_W-1:0];
  endfunction

  function automatic logic cmd_to_palette(input logic [WORD_W-1:0] cmd);
    return cmd[PAL_FLAG_BIT];
  endfunction

  function automatic logic [LEN_FIELD_W-1:0] clip_burst(input logic [LEN_FIELD_W-1:0] left,
                                                        input int unsigned cap);
    if (left > LEN_FIELD_W'(cap)) return LEN_FIELD_W'(cap);
    return left;
  endfunction
endpackage

// File: rtl/frame_dma_walker.sv
module frame_dma_walker
  import frame_dma_pkg::*;
#(
  parameter int BURST  = 16,
  parameter int FREE_W = 6,
  localparam int BL_W  = $clog2(BURST + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic [WORD_W-1:0]     start_addr,
  input  logic                  frame_start,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [WORD_W-1:0]     mem_req_addr,
  output logic [BL_W-1:0]       mem_req_len,
  input  logic                  mem_rsp_valid,
  input  logic                  rsp_accept,
  input  logic [WORD_W-1:0]     mem_rsp_data,
  input  logic [FREE_W-1:0]     fifo_free,
  output logic                  pix_push,
  output logic                  pal_beat,
  output logic                  pal_start
);
  walk_st_t                st;
  logic [WORD_W-1:0]       cur_desc, nxt_desc, src_ptr;
  logic [LEN_FIELD_W-1:0]  left_words, burst;
  logic [BL_W-1:0]         beats_left;
  logic [1:0]              widx;
  logic                    to_pal;

  // named internal events
  logic room_ok, req_fire, beat, desc_last, burst_end, xfer_end;
  walk_st_t after_st;

  always_comb begin
    burst         = clip_burst(left_words, BURST);
    room_ok       = to_pal || (fifo_free >= FREE_W'(BURST));
    mem_req_valid = (st == ST_DREQ) || ((st == ST_XREQ) && room_ok);
    mem_req_addr  = (st == ST_DREQ) ? cur_desc : src_ptr;
    mem_req_len   = (st == ST_DREQ) ? BL_W'(DESC_WORDS) : BL_W'(burst);
    req_fire      = mem_req_valid && mem_req_ready;
    beat          = mem_rsp_valid && rsp_accept && ((st == ST_DRSP) || (st == ST_XRSP));
    pix_push      = beat && (st == ST_XRSP) && !to_pal;
    pal_beat      = beat && (st == ST_XRSP) && to_pal;
    desc_last     = beat && (st == ST_DRSP) && (widx == 2'd3);
    pal_start     = desc_last && cmd_to_palette(mem_rsp_data);
    burst_end     = beat && (st == ST_XRSP) && (beats_left == BL_W'(1));
    xfer_end      = (burst_end && (left_words == LEN_FIELD_W'(1))) ||
                    (desc_last && (cmd_words(mem_rsp_data) == '0));
    after_st      = enable ? ST_DREQ : ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cur_desc   <= '0;
      nxt_desc   <= '0;
      src_ptr    <= '0;
      left_words <= '0;
      beats_left <= '0;
      widx       <= '0;
      to_pal     <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (enable) st <= ST_ARM;
        ST_ARM: begin
          if (!enable) st <= ST_IDLE;
          else if (frame_start) begin
            st       <= ST_DREQ;
            cur_desc <= start_addr;
          end
        end
        ST_DREQ: if (req_fire) begin
          st   <= ST_DRSP;
          widx <= '0;
        end
        ST_DRSP: if (beat) begin
          widx <= widx + 2'd1;
          case (widx)
            2'd0: nxt_desc <= mem_rsp_data;
            2'd1: src_ptr  <= mem_rsp_data;
            2'd2: ;
            default: begin
              left_words <= cmd_words(mem_rsp_data);
              to_pal     <= cmd_to_palette(mem_rsp_data);
              if (xfer_end) begin
                st       <= after_st;
                cur_desc <= nxt_desc;
              end else begin
                st <= ST_XREQ;
              end
            end
          endcase
        end
        ST_XREQ: if (req_fire) begin
          st         <= ST_XRSP;
          beats_left <= BL_W'(burst);
          src_ptr    <= src_ptr + (WORD_W'(burst) << 2);
        end
        ST_XRSP: if (beat) begin
          left_words <= left_words - 1'b1;
          beats_left <= beats_left - 1'b1;
          if (xfer_end) begin
            st       <= after_st;
            cur_desc <= nxt_desc;
          end else if (burst_end) begin
            st <= ST_XREQ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len)));

  // R4
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ((mem_req_len != '0) && (mem_req_len <= BL_W'(BURST))));

  // R2
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_DREQ) && ($past(st) == ST_ARM)) |-> (mem_req_addr == $past(start_addr)));
endmodule

// File: rtl/frame_dma_pal_unpack.sv
module frame_dma_pal_unpack #(
  parameter int PAL_AW = 8,
  parameter int WORD_W = 32,
  localparam int HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pal_start,
  input  logic              pal_beat,
  input  logic [WORD_W-1:0] beat_data,
  output logic              rsp_accept,
  output logic              pal_we,
  output logic [PAL_AW-1:0] pal_addr,
  output logic [HALF_W-1:0] pal_wdata
);
  logic              hold_valid;
  logic [HALF_W-1:0] hold_hi;
  logic [PAL_AW-1:0] next_idx;

  assign rsp_accept = !hold_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_hi    <= '0;
      next_idx   <= '0;
      pal_we     <= 1'b0;
      pal_addr   <= '0;
      pal_wdata  <= '0;
    end else begin
      pal_we <= 1'b0;
      if (pal_start) next_idx <= '0;
      if (pal_beat) begin
        pal_we     <= 1'b1;
        pal_addr   <= next_idx;
        pal_wdata  <= beat_data[HALF_W-1:0];
        next_idx   <= next_idx + 1'b1;
        hold_valid <= 1'b1;
        hold_hi    <= beat_data[WORD_W-1:HALF_W];
      end else if (hold_valid) begin
        pal_we     <= 1'b1;
        pal_addr   <= next_idx;
        pal_wdata  <= hold_hi;
        next_idx   <= next_idx + 1'b1;
        hold_valid <= 1'b0;
      end
    end
  end

  // R7
  pal_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_we && $past(pal_we)) |-> (pal_addr == $past(pal_addr) + 1'b1));

  // R7
  hi_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pal_beat |=> ##1 (pal_we && (pal_wdata == $past(beat_data[WORD_W-1:HALF_W], 2))));
endmodule

// File: rtl/frame_dma_pix_fifo.sv
module frame_dma_pix_fifo #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 32,
  localparam int FREE_W = $clog2(DEPTH + 1),
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pix_rd,
  output logic [WORD_W-1:0] pix_data,
  output logic              underrun,
  output logic [FREE_W-1:0] fifo_free
);
  logic [WORD_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [FREE_W-1:0] count;
  logic              pop, starve;

  assign pop       = pix_rd && (count != '0);
  assign starve    = pix_rd && (count == '0);
  assign fifo_free = FREE_W'(DEPTH) - count;

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      pix_data <= '0;
      underrun <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop) begin
        pix_data <= store[rd_ptr];
        rd_ptr   <= rd_ptr + 1'b1;
      end
      if (starve) underrun <= 1'b1;
      count <= count + FREE_W'(push) - FREE_W'(pop);
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < FREE_W'(DEPTH)));

  // R10
  starve_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    starve |=> (underrun && $stable(pix_data)));

  // R10
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);
endmodule

// File: rtl/frame_dma_fetch.sv
module frame_dma_fetch
  import frame_dma_pkg::*;
#(
  parameter int BURST      = 16,
  parameter int FIFO_DEPTH = 32,
  parameter int PAL_AW     = 8,
  localparam int BL_W      = $clog2(BURST + 1),
  localparam int FREE_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [31:0]       start_addr,
  input  logic              frame_start,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  output logic [BL_W-1:0]   mem_req_len,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [31:0]       mem_rsp_data,
  input  logic              pix_rd,
  output logic [31:0]       pix_data,
  output logic              underrun,
  output logic              pal_we,
  output logic [PAL_AW-1:0] pal_addr,
  output logic [15:0]       pal_wdata
);
  logic              pix_push, pal_beat, pal_start, rsp_accept;
  logic [FREE_W-1:0] fifo_free;

  assign mem_rsp_ready = rsp_accept;

  frame_dma_walker #(.BURST(BURST), .FREE_W(FREE_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_addr(start_addr),
    .frame_start(frame_start), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_len(mem_req_len), .mem_rsp_valid(mem_rsp_valid),
    .rsp_accept(rsp_accept), .mem_rsp_data(mem_rsp_data),
    .fifo_free(fifo_free), .pix_push(pix_push), .pal_beat(pal_beat),
    .pal_start(pal_start)
  );

  frame_dma_pal_unpack #(.PAL_AW(PAL_AW), .WORD_W(WORD_W)) u_pal (
    .clk(clk), .rst_n(rst_n), .pal_start(pal_start), .pal_beat(pal_beat),
    .beat_data(mem_rsp_data), .rsp_accept(rsp_accept), .pal_we(pal_we),
    .pal_addr(pal_addr), .pal_wdata(pal_wdata)
  );

  frame_dma_pix_fifo #(.DEPTH(FIFO_DEPTH), .WORD_W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(pix_push), .push_data(mem_rsp_data),
    .pix_rd(pix_rd), .pix_data(pix_data), .underrun(underrun),
    .fifo_free(fifo_free)
  );

  // R7
  pal_not_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_push && pal_beat));
endmodule

// File: tb/frame_dma_fetch_tb.sv
module frame_dma_fetch_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, enable = 1'b0, frame_start = 1'b0, pix_rd = 1'b0;
  logic [31:0] start_addr = '0;
  logic        mem_req_valid, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [31:0] mem_req_addr, mem_rsp_data = '0, pix_data;
  logic [4:0]  mem_req_len;
  logic        underrun, pal_we;
  logic [7:0]  pal_addr;
  logic [15:0] pal_wdata;

  frame_dma_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_addr(start_addr),
    .frame_start(frame_start), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_len(mem_req_len), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .pix_rd(pix_rd), .pix_data(pix_data), .underrun(underrun),
    .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata)
  );

  int total = 0, bad = 0;
  logic [31:0] mem [0:1023];

  function automatic logic [31:0] pat(input int w);
    return {16'(w) ^ 16'hC3A5, 16'(w * 7 + 3)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory model and request log
  int rl = 0, ra = 0, qa = 0, ql = 0, cyc = 0, req_n = 0, pix_req_words = 0;
  bit rf_pend = 0, qf_pend = 0, hold_pend = 0;
  logic [31:0] h_a;
  logic [4:0]  h_l;
  logic [31:0] log_addr [0:63];
  int          log_len  [0:63];

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        rl = 0; rf_pend = 0; qf_pend = 0; hold_pend = 0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
      end else begin
        if (hold_pend)  // R9
          chk(mem_req_valid && mem_req_addr == h_a && mem_req_len == h_l,
              "R9 held request", mem_req_addr, h_a);
        if (rf_pend) begin ra++; rl--; end
        if (qf_pend) begin ra = qa; rl = ql; end
        mem_req_ready = (rl == 0) && ((cyc % 5) != 2);
        mem_rsp_valid = (rl > 0);
        mem_rsp_data  = mem[ra & 1023];
        qf_pend = mem_req_valid && mem_req_ready;
        hold_pend = mem_req_valid && !mem_req_ready;
        h_a = mem_req_addr; h_l = mem_req_len;
        if (qf_pend) begin
          qa = int'(mem_req_addr >> 2); ql = int'(mem_req_len);
          if (req_n < 64) begin log_addr[req_n] = mem_req_addr; log_len[req_n] = ql; end
          req_n++;
          if (qa >= 256 && qa < 512) pix_req_words += ql;
        end
        rf_pend = mem_rsp_valid && mem_rsp_ready;
      end
    end
  end

  // palette write monitor
  int pal_k = 0, pk;
  logic [31:0] pw;
  logic [15:0] pe;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && pal_we) begin
        pk = pal_k % 256;
        pw = pat(512 + pk / 2);
        pe = pk[0] ? pw[31:16] : pw[15:0];
        // R7 two entries per word, low half first, index from 0
        chk(pal_addr == 8'(pk) && pal_wdata == pe, "R7 palette write",
            {16'(pal_addr), pal_wdata}, {16'(pk), pe});
        pal_k++;
      end
    end
  end

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog R6 act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_pix(output logic [31:0] v);
    pix_rd = 1'b1;
    @(negedge clk);
    pix_rd = 1'b0;
    v = pix_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; enable = 1'b0; frame_start = 1'b0; pix_rd = 1'b0;
    tick(3);
    req_n = 0; pix_req_words = 0; pal_k = 0;
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic pulse_fs();
    frame_start = 1'b1;
    tick(1);
    frame_start = 1'b0;
  endtask

  task automatic put_desc(input int ba, input int nxt, input int src, input int id, input int cmd);
    mem[(ba >> 2)]     = 32'(nxt);
    mem[(ba >> 2) + 1] = 32'(src);
    mem[(ba >> 2) + 2] = 32'(id);
    mem[(ba >> 2) + 3] = 32'(cmd);
  endtask

  task automatic chk_req(input int i, input int a, input int l, input string tag);
    chk(log_addr[i] == 32'(a) && log_len[i] == l, tag, log_addr[i], 32'(a));
  endtask

  logic [31:0] v, lv;
  int rd_idx, n0, cnt, left;

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = pat(i);
    tick(2);
    do_reset();
    // R1
    chk(!mem_req_valid, "R1 reset request", 32'(mem_req_valid), 0);
    chk(pix_data == 0, "R1 reset pix_data", pix_data, 0);
    chk(!underrun, "R1 reset underrun", 32'(underrun), 0);
    chk(!pal_we, "R1 reset pal_we", 32'(pal_we), 0);

    // true colour: self-looping 40-word frame
    put_desc(32'h100, 32'h100, 32'h400, 32'hDEAD0001, 40);
    start_addr = 32'h100;
    enable = 1'b1;
    tick(30);
    chk(req_n == 0, "R2 no fetch before frame_start", 32'(req_n), 0);
    pulse_fs();
    tick(200);
    chk(req_n == 3, "R5 requests with no pulls", 32'(req_n), 3);
    chk(pix_req_words == 32, "R5 pixel words with no pulls", 32'(pix_req_words), 32);
    chk_req(0, 32'h100, 4, "R2 first descriptor read");
    chk_req(1, 32'h400, 16, "R4 first burst");
    chk_req(2, 32'h440, 16, "R4 second burst");
    rd_idx = 0;
    for (int i = 0; i < 120; i++) begin
      read_pix(v);
      chk(v == pat(256 + rd_idx % 40), "R6 pixel order", v, pat(256 + rd_idx % 40));
      lv = v; rd_idx++;
      tick(1);
      if (i == 50) pulse_fs();  // R11 ignored while running
    end
    chk(!underrun, "R6 no underrun while fed", 32'(underrun), 0);
    chk_req(3, 32'h480, 8, "R4 short last burst");
    chk_req(4, 32'h100, 4, "R6 self-pointing descriptor refetched");
    chk_req(5, 32'h400, 16, "R6 buffer repeats");
    for (int i = 0; i < 64 && i < req_n; i++)
      if (log_len[i] == 4) chk(log_addr[i] == 32'h100, "R11 stray frame_start", log_addr[i], 32'h100);

    // stop at a descriptor boundary, then drain into underrun
    tick(200);
    enable = 1'b0;
    for (int r = 0; r < 8; r++) begin
      tick(100);
      left = pix_req_words - rd_idx;
      cnt = (left < 10) ? left : 10;
      for (int j = 0; j < cnt; j++) begin
        read_pix(v);
        chk(v == pat(256 + rd_idx % 40), "R11 order while stopping", v, pat(256 + rd_idx % 40));
        lv = v; rd_idx++;
      end
    end
    tick(100);
    n0 = req_n;
    tick(100);
    chk(req_n == n0, "R11 no requests after enable low", 32'(req_n), 32'(n0));
    chk(!mem_req_valid, "R11 idle after enable low", 32'(mem_req_valid), 0);
    chk(n0 <= 64 && log_addr[n0 - 1] == 32'h480 && log_len[n0 - 1] == 8,
        "R11 stopped after transfer end", log_addr[n0 - 1], 32'h480);
    left = pix_req_words - rd_idx;
    for (int j = 0; j < left; j++) begin
      read_pix(v);
      chk(v == pat(256 + rd_idx % 40), "R6 drain order", v, pat(256 + rd_idx % 40));
      lv = v; rd_idx++;
    end
    chk(!underrun, "R10 no underrun before empty", 32'(underrun), 0);
    read_pix(v);
    chk(v == lv && underrun, "R10 repeat on empty", v, lv);
    tick(5);
    read_pix(v);
    chk(v == lv && underrun, "R10 underrun sticky", {31'd0, underrun}, 1);

    // palette chain: P -> Z(len 0) -> F -> P
    do_reset();
    chk(!underrun, "R10 cleared by reset", 32'(underrun), 0);
    put_desc(32'h200, 32'h220, 32'h800, 32'h11111111, (1 << 28) | 128);
    put_desc(32'h220, 32'h210, 32'h000, 32'h22222222, 0);
    put_desc(32'h210, 32'h200, 32'h400, 32'h33333333, 24);
    start_addr = 32'h200;
    enable = 1'b1;
    tick(3);
    pulse_fs();
    tick(400);
    rd_idx = 0;
    for (int i = 0; i < 72; i++) begin
      read_pix(v);
      chk(v == pat(256 + rd_idx % 24), "R8 only frame words on pix_data", v, pat(256 + rd_idx % 24));
      rd_idx++;
      tick(20);
    end
    chk(!underrun, "R8 no underrun", 32'(underrun), 0);
    chk(pal_k >= 768, "R8 palette reloaded per pass", 32'(pal_k), 768);
    chk(pal_k % 256 == 0 || pal_k > 768, "R7 whole palette passes", 32'(pal_k), 768);
    chk_req(0, 32'h200, 4, "R2 chain start");
    for (int i = 0; i < 8; i++) chk_req(1 + i, 32'h800 + 64 * i, 16, "R7 palette bursts");
    chk_req(9, 32'h220, 4, "R3 zero-length descriptor read");
    chk_req(10, 32'h210, 4, "R3 zero-length skipped to next");
    chk_req(11, 32'h400, 16, "R4 frame burst");
    chk_req(12, 32'h440, 8, "R4 frame tail burst");
    chk_req(13, 32'h200, 4, "R8 back to palette descriptor");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule